// File: doc/BRIEF.md
# Interleaved Substring Match Combiner

A multi-byte string search engine can run one small byte-wide matcher per lane. Each input word is `LANES` bytes wide, and lane x only ever sees byte x of each word. Every search string is broken into `LANES` interleaved pieces: piece y takes every `LANES`-th byte of the string. The pieces are numbered by the order in which their final bytes arrive. Each lane matcher raises one bit per (string, piece) when it finishes a piece. This block turns those per-lane report vectors into a single hit bit per string.

The tail of a string can start anywhere inside a word. Its final `LANES` bytes can therefore sit wholly in one word, or be split across two consecutive words. The split is called the alignment c, where 0 <= c < `LANES`: c of those bytes arrive in the earlier word and the rest in the later word. For each alignment the block checks one fixed lane-to-piece pattern, using a one-cycle-delayed copy of the lane reports for the pieces that finished in the earlier word. The string hit is the OR of these alignment patterns. The logic does not depend on the string contents, so it is repeated unchanged for each of the `STRINGS` strings.

The block is used between the bank of lane matchers and whatever consumes per-string hits.

Top module: `smc_combiner`

## Requirements
- R1: While `rst_n` is low at a clock edge, `match_o` is all zero after that edge, and every delayed lane copy is cleared.
- R2: Alignment 0: when, for every piece y, lane y reports piece y of string s in the same cycle, `match_o[s]` is 1 one edge later.
- R3: Alignment c > 0: piece i of string s must come from lane (i - c) mod `LANES`. Pieces with i < c must be reported one cycle before the pieces with i >= c. When all of them arrive in that way, `match_o[s]` is 1. If the pieces with i < c are reported in the same cycle as the rest instead, there is no hit.
- R4: `match_o` is registered. It reflects the lane reports sampled at the previous edge together with those sampled one edge earlier, so a single completing word gives a hit pulse exactly one cycle long.
- R5: If any single piece of a pattern is missing, there is no hit for that string.
- R6: If the right pieces are reported by the wrong lanes (the pattern rotated by one lane), there is no hit.
- R7: Bit s*`LANES` + y of lane x's vector is piece y of string s. Lane x's vector occupies bits x*`STRINGS`*`LANES` upward of `lane_hits_i`. Strings are evaluated independently, and several may hit in the same cycle.
- R8: Pieces from the earlier word count only when they were reported exactly one cycle before the rest. A two-cycle gap gives no hit.
- R9: Lane reports seen before a reset cycle can never combine with reports seen after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| lane_hits_i | input | LANES*STRINGS*LANES | Per-lane piece completion reports, packed as in R7 |
| match_o | output | STRINGS | Registered per-string hit |

## Verification
Each alignment is driven on several strings with a correct lane-to-piece pattern. This shows that the delayed and current halves are wired to the right lanes. Near-miss patterns separate the individual conditions of a match:
- a single dropped piece tests the AND of all lanes;
- a lane rotation tests the lane mapping;
- sending the earlier pieces in the same word tests the use of the delayed copy;
- a one-word gap tests that the delay is exactly one cycle.

Directed cases cover reset clearing the delayed copies, two strings hitting at once at different alignments, and saturated inputs that hit every string.

// File: rtl/smc_pkg.sv
// Shared helpers for the interleaved substring match combiner.
// Assumes lane-major packing: lane, then string, then piece.
package smc_pkg;

    // Flat bit position of piece `sub` of string `str` as reported by lane `lane`.
    function automatic int hit_index(input int lane, input int str, input int sub,
                                     input int strings, input int lanes);
        return lane * strings * lanes + str * lanes + sub;
    endfunction

    // Lane that must report piece `sub` for alignment `align`.
    function automatic int source_lane(input int sub, input int align, input int lanes);
        return (sub - align + lanes) % lanes;
    endfunction

endpackage

// File: rtl/smc_align_term.sv
// One alignment term for one string: the AND of LANES lane signals.
// Pieces with index below ALIGN are taken from a one-cycle-delayed copy.
// Assumes cur_hits is lane-major for a single string: bit lane*LANES + piece.
module smc_align_term
    import smc_pkg::*;
#(
    parameter int LANES = 4,
    parameter int ALIGN = 0
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [LANES*LANES-1:0] cur_hits,
    output logic                   term
);

    logic [LANES-1:0] picked;

    for (genvar i = 0; i < LANES; i++) begin : g_piece
        localparam int SRC = source_lane(i, ALIGN, LANES);
        if (i < ALIGN) begin : g_delayed
            logic prev_q;
            // Keep the earlier word's report for this piece; cleared by reset.
            always_ff @(posedge clk) begin
                if (!rst_n) prev_q <= 1'b0;
                else        prev_q <= cur_hits[SRC*LANES + i];
            end
            assign picked[i] = prev_q;
        end else begin : g_current
            assign picked[i] = cur_hits[SRC*LANES + i];
        end
    end

    // Every lane must agree for this alignment.
    always_comb term = &picked;

endmodule

// File: rtl/smc_string_cell.sv
// Full combine for one search string: OR over all LANES alignment terms.
// Assumes the caller has gathered this string's pieces from every lane.
module smc_string_cell #(
    parameter int LANES = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [LANES*LANES-1:0] cur_hits,
    output logic                   str_hit
);

    logic [LANES-1:0] terms;

    for (genvar c = 0; c < LANES; c++) begin : g_align
        smc_align_term #(.LANES(LANES), .ALIGN(c)) term_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .cur_hits (cur_hits),
            .term     (terms[c])
        );
    end

    // The string is present if any alignment is satisfied.
    always_comb str_hit = |terms;

endmodule

// File: rtl/smc_combiner.sv
// Top: regroups the per-lane report vectors by string, runs one combine cell
// per string and registers the per-string hits.
// Assumes reports are single-cycle pulses from identical byte-lane matchers.
module smc_combiner
    import smc_pkg::*;
#(
    parameter int LANES   = 4,
    parameter int STRINGS = 3
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic [LANES*STRINGS*LANES-1:0]     lane_hits_i,
    output logic [STRINGS-1:0]                 match_o
);

    localparam int CELL_W = LANES * LANES;

    logic [STRINGS-1:0] hit_now;

    for (genvar s = 0; s < STRINGS; s++) begin : g_str
        logic [CELL_W-1:0] gathered;
        for (genvar x = 0; x < LANES; x++) begin : g_lane
            for (genvar y = 0; y < LANES; y++) begin : g_sub
                assign gathered[x*LANES + y] = lane_hits_i[hit_index(x, s, y, STRINGS, LANES)];
            end
        end
        smc_string_cell #(.LANES(LANES)) cell_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .cur_hits (gathered),
            .str_hit  (hit_now[s])
        );
    end

    // Register the per-string hits; cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) match_o <= '0;
        else        match_o <= hit_now;
    end

endmodule

// File: rtl/smc_combiner_chk.sv
// Assertion checker bound to smc_combiner. Observes ports only.
module smc_combiner_chk #(
    parameter int LANES   = 4,
    parameter int STRINGS = 3
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic [LANES*STRINGS*LANES-1:0] lane_hits_i,
    input logic [STRINGS-1:0]             match_o
);

    logic [STRINGS*LANES-1:0] any_sub;
    logic [STRINGS-1:0]       diag_all;

    // Per string and piece: did any lane report it; is the alignment-0 pattern present.
    always_comb begin
        any_sub  = '0;
        diag_all = '1;
        for (int s = 0; s < STRINGS; s++) begin
            for (int y = 0; y < LANES; y++) begin
                for (int x = 0; x < LANES; x++) begin
                    if (lane_hits_i[x*STRINGS*LANES + s*LANES + y]) any_sub[s*LANES + y] = 1'b1;
                end
                if (!lane_hits_i[y*STRINGS*LANES + s*LANES + y]) diag_all[s] = 1'b0;
            end
        end
    end

    assert_reset_clear_R1: assert property (@(posedge clk) !rst_n |=> (match_o == '0));

    assert_quiet_input_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_hits_i == '0) |=> (match_o == '0));

    for (genvar s = 0; s < STRINGS; s++) begin : g_s
        assert_align_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
            diag_all[s] |=> match_o[s]);

        assert_last_piece_now_R3: assert property (@(posedge clk) disable iff (!rst_n)
            match_o[s] |-> $past(any_sub[s*LANES + LANES - 1]));

        assert_first_piece_recent_R8: assert property (@(posedge clk) disable iff (!rst_n)
            match_o[s] |-> ($past(any_sub[s*LANES]) || $past(any_sub[s*LANES], 2)));
    end

endmodule

bind smc_combiner smc_combiner_chk #(.LANES(LANES), .STRINGS(STRINGS)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .lane_hits_i (lane_hits_i),
    .match_o     (match_o)
);

// File: tb/smc_combiner_tb.sv
// Self-checking bench: table of pattern rows, then directed reset and corner tests.
module smc_combiner_tb_top;

    localparam int W = 4;
    localparam int S = 3;
    localparam int N = W * S * W;

    // Pattern modes: 0 correct, 1 drop one piece, 2 rotate lanes, 3 no delay, 4 one-word gap
    typedef struct packed {
        logic [3:0] str;
        logic [3:0] align;
        logic [3:0] mode;
        logic [3:0] drop;
        logic       exp;
    } row_t;

    localparam int NROWS = 16;
    localparam row_t ROWS [NROWS] = '{
        '{4'd0, 4'd0, 4'd0, 4'd0, 1'b1},
        '{4'd1, 4'd1, 4'd0, 4'd0, 1'b1},
        '{4'd2, 4'd2, 4'd0, 4'd0, 1'b1},
        '{4'd0, 4'd3, 4'd0, 4'd0, 1'b1},
        '{4'd2, 4'd0, 4'd0, 4'd0, 1'b1},
        '{4'd1, 4'd3, 4'd0, 4'd0, 1'b1},
        '{4'd0, 4'd1, 4'd1, 4'd0, 1'b0},
        '{4'd1, 4'd2, 4'd1, 4'd3, 1'b0},
        '{4'd2, 4'd3, 4'd1, 4'd1, 1'b0},
        '{4'd0, 4'd2, 4'd1, 4'd2, 1'b0},
        '{4'd0, 4'd0, 4'd2, 4'd0, 1'b0},
        '{4'd1, 4'd2, 4'd2, 4'd0, 1'b0},
        '{4'd2, 4'd1, 4'd3, 4'd0, 1'b0},
        '{4'd0, 4'd3, 4'd3, 4'd0, 1'b0},
        '{4'd1, 4'd1, 4'd4, 4'd0, 1'b0},
        '{4'd2, 4'd2, 4'd4, 4'd0, 1'b0}
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] hits = '0;
    logic [S-1:0] match;
    int           checks = 0;
    int           errors = 0;
    bit           done = 1'b0;

    always #5 clk = ~clk;

    smc_combiner #(.LANES(W), .STRINGS(S)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .lane_hits_i (hits),
        .match_o     (match)
    );

    task automatic check(input logic [S-1:0] act, input logic [S-1:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: match_o=%b expected %b", tag, act, exp);
        end
    endtask

    // Build earlier-word and later-word reports for one string and alignment.
    function automatic void build(input int s, input int c, input int mode, input int drop,
                                  output logic [N-1:0] pv, output logic [N-1:0] cv);
        pv = '0;
        cv = '0;
        for (int i = 0; i < W; i++) begin
            int lane;
            if (mode == 1 && i == drop) continue;
            lane = (i - c + W) % W;
            if (mode == 2) lane = (lane + 1) % W;
            if (i < c && mode != 3) pv[lane*S*W + s*W + i] = 1'b1;
            else                    cv[lane*S*W + s*W + i] = 1'b1;
        end
    endfunction

    function automatic string tag_of(input int mode, input int c);
        case (mode)
            0: return (c == 0) ? "R2" : "R3";
            1: return "R5";
            2: return "R6";
            3: return "R3";
            default: return "R8";
        endcase
    endfunction

    // Drive earlier word, optional idle gap, later word; check the hit and the pulse end.
    task automatic run_pair(input logic [N-1:0] pv, input logic [N-1:0] cv, input bit gap,
                            input logic [S-1:0] exp, input string tag);
        @(negedge clk) hits = '0;
        @(negedge clk) hits = pv;
        if (gap) @(negedge clk) hits = '0;
        @(negedge clk) hits = cv;
        @(negedge clk);
        check(match, exp, tag);
        hits = '0;
        @(negedge clk);
        check(match, '0, "R4 pulse ends");
    endtask

    initial begin
        logic [N-1:0] pv, cv, pv2, cv2;
        hits = '1;
        repeat (3) @(negedge clk);
        check(match, '0, "R1 reset state");
        rst_n = 1'b1;
        hits = '0;

        for (int r = 0; r < NROWS; r++) begin
            build(int'(ROWS[r].str), int'(ROWS[r].align), int'(ROWS[r].mode),
                  int'(ROWS[r].drop), pv, cv);
            run_pair(pv, cv, ROWS[r].mode == 4,
                     ROWS[r].exp ? (S'(1) << ROWS[r].str) : '0,
                     tag_of(int'(ROWS[r].mode), int'(ROWS[r].align)));
        end

        // R7: two strings at different alignments in the same cycle
        build(0, 1, 0, 0, pv, cv);
        build(2, 3, 0, 0, pv2, cv2);
        run_pair(pv | pv2, cv | cv2, 1'b0, 3'b101, "R7 two strings");

        // R7: a string's pattern placed in another string's bit positions does not hit it
        build(1, 2, 0, 0, pv, cv);
        run_pair(pv, cv, 1'b0, 3'b010, "R7 string isolation");

        // R9: earlier-word pieces before a reset cycle must not complete afterwards
        build(1, 2, 0, 0, pv, cv);
        @(negedge clk) hits = pv;
        rst_n = 1'b0;
        @(negedge clk) rst_n = 1'b1;
        hits = cv;
        @(negedge clk);
        check(match, '0, "R9 reset clears earlier word");
        hits = '0;

        // R1: reset in the middle of saturated input holds match_o at zero
        @(negedge clk) hits = '1;
        rst_n = 1'b0;
        @(negedge clk);
        check(match, '0, "R1 reset under load");
        rst_n = 1'b1;
        @(negedge clk);
        check(match, '1, "R2 saturated input hits all strings");
        hits = '0;
        @(negedge clk);
        check(match, '0, "R4 saturated pulse ends");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule